// File: doc/BRIEF.md
# Lockable Control Register Bank

This block holds the byte-wide configuration registers of a motor-driver control path. A simple port carries a 4-bit offset, a data byte, a write strobe and a read strobe; the framing logic in front of it turns serial frames into these strobes. Each implemented register comes out of reset with its own value. Every bit has its own access rule: ordinary read/write, reserved bits that always read back as zero, and a clear-fault command bit that clears itself.

A 3-bit lock field at offset 3h works as a password. Writing the lock code 110b freezes every other register against writes. Writing the unlock code 011b releases the freeze. The lock field itself stays writable while the bank is locked. The stored fields are decoded and driven out as named configuration outputs. The clear-fault command is driven out as a single-cycle pulse.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset the registers read back as: 3h=00h, 4h=60h, 5h=46h, 6h=10h, 7h=00h, 8h=00h, Ch=00h. After reset `locked`, `clr_fault` and `rdata` are 0.
- R2: Read/write bits store the byte written to an implemented offset, and a later read returns that value.
- R3: Reserved zero bits always read 0, whatever is written to them. These are offset 3h bits 7:3, offset 5h bit 7, offset 8h bits 7:6 and offset Ch bits 7:5.
- R4: A write to any offset other than 3h, 4h, 5h, 6h, 7h, 8h or Ch changes no register. A read from such an offset returns 00h.
- R5: Writing 110b to offset 3h bits 2:0 raises `locked` from the next cycle on. While `locked` is 1, writes to offsets 4h, 5h, 6h, 7h, 8h and Ch leave them unchanged.
- R6: Writing 011b to offset 3h bits 2:0 clears `locked`. Writing any other value there leaves `locked` as it was.
- R7: While `locked` is 1, a write to offset 3h still updates bits 2:0, and the new value reads back.
- R8: Writing offset 4h with bit 0 set, while unlocked, drives `clr_fault` high for exactly the one cycle after the write. Bit 0 then reads back 0. When the bank is locked, such a write gives no pulse.
- R9: `rdata` takes the addressed value in the cycle after `rd_en` and holds it until the next read. Reads change no state.
- R10: The decoded outputs follow the bit positions of their registers. `pwm_mode` is offset 4h bits 2:1, `ocp_mode` is offset 6h bits 1:0, `csa_gain` is offset 7h bits 1:0 and `dly_target` is offset Ch bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| locked | output | 1 | Bank is write-frozen |
| clr_fault | output | 1 | One-cycle clear-fault pulse |
| sdo_push_pull | output | 1 | Serial output drive type select |
| slew_sel | output | 2 | Output slew rate select |
| pwm_mode | output | 2 | Input PWM mode select |
| full_duty_fast | output | 1 | Fast frequency at full duty |
| ovp_low_thresh | output | 1 | Lower overvoltage threshold select |
| ovp_en | output | 1 | Overvoltage protection enable |
| otw_report | output | 1 | Report thermal warning on fault pin |
| drv_off | output | 1 | Request low-power standby |
| ocp_cycle_clr | output | 1 | Clear overcurrent on each PWM cycle |
| ocp_deglitch | output | 2 | Overcurrent deglitch select |
| ocp_retry_long | output | 1 | Long overcurrent retry interval |
| ocp_level_high | output | 1 | Higher overcurrent trip level |
| ocp_mode | output | 2 | Overcurrent response select |
| ilim_coast | output | 1 | Current-limit recirculation through diodes |
| aar_en | output | 1 | Asynchronous rectification enable |
| asr_en | output | 1 | Synchronous rectification enable |
| csa_gain | output | 2 | Sense amplifier gain select |
| buck_seq_dis | output | 1 | Regulator power sequencing disable |
| buck_ilim_low | output | 1 | Lower regulator current limit |
| buck_vsel | output | 2 | Regulator output voltage select |
| buck_dis | output | 1 | Regulator disable |
| dly_comp_en | output | 1 | Driver delay compensation enable |
| dly_target | output | 4 | Delay compensation target |

## Verification
The hardest case to reach is a locked bank that gets a stream of writes. The register contents must stay frozen while the lock field keeps changing. A clear-fault write during that time must give no pulse. The stimulus first writes distinct values everywhere, then locks the bank. It then writes to a frozen register and to the command bit, and writes a non-unlock code into the lock field. A read confirms the new code, and `locked` is checked to be still high. Finally the bank is unlocked, and one write shows that normal access is back.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int NUM_REGS = 7;
    localparam int CODE_W   = 3;

    localparam int LOCK_IDX = 0;
    localparam int CMD_IDX  = 1;

    localparam logic [CODE_W-1:0] LOCK_CODE   = 3'b110;
    localparam logic [CODE_W-1:0] UNLOCK_CODE = 3'b011;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    function automatic addr_t reg_addr(input int idx);
        case (idx)
            0:       return addr_t'(4'h3);
            1:       return addr_t'(4'h4);
            2:       return addr_t'(4'h5);
            3:       return addr_t'(4'h6);
            4:       return addr_t'(4'h7);
            5:       return addr_t'(4'h8);
            default: return addr_t'(4'hC);
        endcase
    endfunction

    function automatic byte_t reset_val(input int idx);
        case (idx)
            1:       return 8'h60;
            2:       return 8'h46;
            3:       return 8'h10;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t rz_mask(input int idx);
        case (idx)
            0:       return 8'hF8;
            2:       return 8'h80;
            5:       return 8'hC0;
            6:       return 8'hE0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t sc_mask(input int idx);
        return (idx == CMD_IDX) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/crb_decode.sv
module crb_decode
    import crb_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  addr_t             addr,
    output logic [N_REGS-1:0] hit
);

    for (genvar g = 0; g < N_REGS; g++) begin : g_hit
        assign hit[g] = (addr == reg_addr(g));
    end

endmodule

// File: rtl/crb_lock.sv
module crb_lock
    import crb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lock,
    input  logic [CODE_W-1:0] code,
    output logic              locked
);

    typedef struct packed {
        logic locked;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lock) begin
            if (code == LOCK_CODE) begin
                st_d.locked = 1'b1;
            end else if (code == UNLOCK_CODE) begin
                st_d.locked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

    assert_lock_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && code == LOCK_CODE) |=> locked);

    assert_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && code == UNLOCK_CODE) |=> !locked);

    assert_other_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lock || (code != LOCK_CODE && code != UNLOCK_CODE)) |=> $stable(locked));

endmodule

// File: rtl/crb_regfile.sv
module crb_regfile
    import crb_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [N_REGS-1:0]             hit,
    input  byte_t                         wdata,
    input  logic                          locked,
    output logic [N_REGS-1:0][DATA_W-1:0] regs,
    output logic                          clr_pulse
);

    typedef struct packed {
        logic [N_REGS-1:0][DATA_W-1:0] regs;
    } rf_st_t;

    rf_st_t            st_d, st_q;
    logic [N_REGS-1:0] wr_allow;

    for (genvar g = 0; g < N_REGS; g++) begin : g_allow
        if (g == LOCK_IDX) begin : g_lockreg
            assign wr_allow[g] = wr_en && hit[g];
        end else begin : g_plain
            assign wr_allow[g] = wr_en && hit[g] && !locked;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_REGS; i++) begin
            if (wr_allow[i]) begin
                st_d.regs[i] = wdata & ~rz_mask(i);
            end else begin
                st_d.regs[i] = st_q.regs[i] & ~sc_mask(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) begin
                st_q.regs[i] <= reset_val(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign regs      = st_q.regs;
    assign clr_pulse = st_q.regs[CMD_IDX][0];

    for (genvar g = 0; g < N_REGS; g++) begin : g_chk
        if (g != LOCK_IDX) begin : g_frozen
            assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (locked && wr_en && hit[g]) |=>
                    $stable(regs[g] & ~sc_mask(g)));
        end
        assert_rz_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hit[g]) |=> ((regs[g] & rz_mask(g)) == '0));
    end

    assert_unmapped_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit == '0) |=> $stable(regs[LOCK_IDX]));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !(wr_en && hit[CMD_IDX] && wdata[0] && !locked)) |=> !clr_pulse);

    assert_no_pulse_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr_pulse) |=> !clr_pulse);

endmodule

// File: rtl/crb_rdmux.sv
module crb_rdmux
    import crb_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [N_REGS-1:0]             hit,
    input  logic [N_REGS-1:0][DATA_W-1:0] regs,
    output byte_t                         rdata
);

    typedef struct packed {
        byte_t rdata;
    } rd_st_t;

    rd_st_t st_d, st_q;
    byte_t  sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (hit[i]) begin
                sel = sel | regs[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rdata = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    assert_rd_unmapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit == '0) |=> (rdata == '0));

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
    import crb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic [7:0] rdata,
    output logic       locked,
    output logic       clr_fault,
    output logic       sdo_push_pull,
    output logic [1:0] slew_sel,
    output logic [1:0] pwm_mode,
    output logic       full_duty_fast,
    output logic       ovp_low_thresh,
    output logic       ovp_en,
    output logic       otw_report,
    output logic       drv_off,
    output logic       ocp_cycle_clr,
    output logic [1:0] ocp_deglitch,
    output logic       ocp_retry_long,
    output logic       ocp_level_high,
    output logic [1:0] ocp_mode,
    output logic       ilim_coast,
    output logic       aar_en,
    output logic       asr_en,
    output logic [1:0] csa_gain,
    output logic       buck_seq_dis,
    output logic       buck_ilim_low,
    output logic [1:0] buck_vsel,
    output logic       buck_dis,
    output logic       dly_comp_en,
    output logic [3:0] dly_target
);

    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic                            lock_q;
    logic [10:0]                     unused_rsvd;

    crb_decode #(.N_REGS(NUM_REGS)) i_decode (
        .addr (addr),
        .hit  (hit)
    );

    crb_lock i_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lock (wr_en && hit[LOCK_IDX]),
        .code    (wdata[CODE_W-1:0]),
        .locked  (lock_q)
    );

    crb_regfile #(.N_REGS(NUM_REGS)) i_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .hit       (hit),
        .wdata     (wdata),
        .locked    (lock_q),
        .regs      (regs),
        .clr_pulse (clr_fault)
    );

    crb_rdmux #(.N_REGS(NUM_REGS)) i_rdmux (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .hit   (hit),
        .regs  (regs),
        .rdata (rdata)
    );

    assign locked = lock_q;

    // offset 4h
    assign sdo_push_pull  = regs[1][5];
    assign slew_sel       = regs[1][4:3];
    assign pwm_mode       = regs[1][2:1];
    // offset 5h
    assign full_duty_fast = regs[2][4];
    assign ovp_low_thresh = regs[2][3];
    assign ovp_en         = regs[2][2];
    assign otw_report     = regs[2][0];
    // offset 6h
    assign drv_off        = regs[3][7];
    assign ocp_cycle_clr  = regs[3][6];
    assign ocp_deglitch   = regs[3][5:4];
    assign ocp_retry_long = regs[3][3];
    assign ocp_level_high = regs[3][2];
    assign ocp_mode       = regs[3][1:0];
    // offset 7h
    assign ilim_coast     = regs[4][6];
    assign aar_en         = regs[4][3];
    assign asr_en         = regs[4][2];
    assign csa_gain       = regs[4][1:0];
    // offset 8h
    assign buck_seq_dis   = regs[5][4];
    assign buck_ilim_low  = regs[5][3];
    assign buck_vsel      = regs[5][2:1];
    assign buck_dis       = regs[5][0];
    // offset Ch
    assign dly_comp_en    = regs[6][4];
    assign dly_target     = regs[6][3:0];

    // reserved storage bits with no decoded function
    assign unused_rsvd = {regs[0][7:0] != 8'h00, regs[1][7:6], regs[2][7:5], regs[2][1],
                          regs[4][7], regs[4][5:4], regs[5][7:5] != 3'b000};

endmodule

// File: tb/test_ctl_reg_bank.sv
module test_ctl_reg_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       locked, clr_fault;
    logic       sdo_push_pull, full_duty_fast, ovp_low_thresh, ovp_en, otw_report;
    logic       drv_off, ocp_cycle_clr, ocp_retry_long, ocp_level_high;
    logic       ilim_coast, aar_en, asr_en, buck_seq_dis, buck_ilim_low, buck_dis, dly_comp_en;
    logic [1:0] slew_sel, pwm_mode, ocp_deglitch, ocp_mode, csa_gain, buck_vsel;
    logic [3:0] dly_target;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];
    logic rd_fire = 1'b0;

    always #4 clk = ~clk;

    ctl_reg_bank i_ctl_reg_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .locked(locked), .clr_fault(clr_fault),
        .sdo_push_pull(sdo_push_pull), .slew_sel(slew_sel), .pwm_mode(pwm_mode),
        .full_duty_fast(full_duty_fast), .ovp_low_thresh(ovp_low_thresh),
        .ovp_en(ovp_en), .otw_report(otw_report), .drv_off(drv_off),
        .ocp_cycle_clr(ocp_cycle_clr), .ocp_deglitch(ocp_deglitch),
        .ocp_retry_long(ocp_retry_long), .ocp_level_high(ocp_level_high),
        .ocp_mode(ocp_mode), .ilim_coast(ilim_coast), .aar_en(aar_en),
        .asr_en(asr_en), .csa_gain(csa_gain), .buck_seq_dis(buck_seq_dis),
        .buck_ilim_low(buck_ilim_low), .buck_vsel(buck_vsel), .buck_dis(buck_dis),
        .dly_comp_en(dly_comp_en), .dly_target(dly_target)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        e.val = exp; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: pops one expected byte per completed read
    always @(posedge clk) rd_fire <= rd_en;

    always @(negedge clk) begin
        if (rd_fire) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9: unexpected read data %0h, expected none", rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({24'h0, rdata}, {24'h0, e.val}, e.tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({31'h0, locked}, 0, "R1 locked after reset");
        check({31'h0, clr_fault}, 0, "R1 clr_fault after reset");
        check({24'h0, rdata}, 0, "R1 rdata after reset");

        rd(4'h3, 8'h00, "R1 reset 3h");
        rd(4'h4, 8'h60, "R1 reset 4h");
        rd(4'h5, 8'h46, "R1 reset 5h");
        rd(4'h6, 8'h10, "R1 reset 6h");
        rd(4'h7, 8'h00, "R1 reset 7h");
        rd(4'h8, 8'h00, "R1 reset 8h");
        rd(4'hC, 8'h00, "R1 reset Ch");
        for (int a = 0; a < 16; a++) begin
            if (!(a inside {3, 4, 5, 6, 7, 8, 12})) rd(4'(a), 8'h00, "R4 unmapped read");
        end

        // R2 / R3 / R10 writes
        wr(4'h4, 8'hFE);
        rd(4'h4, 8'hFE, "R2 readback 4h");
        check({30'h0, pwm_mode}, 2'b11, "R10 pwm_mode");
        wr(4'h5, 8'hFF);
        rd(4'h5, 8'h7F, "R3 5h bit7 zero");
        wr(4'h3, 8'hFF);
        rd(4'h3, 8'h07, "R3 3h upper zero");
        check({31'h0, locked}, 0, "R6 code 7 no lock");
        wr(4'h6, 8'h5A);
        rd(4'h6, 8'h5A, "R2 readback 6h");
        check({30'h0, ocp_mode}, 2'b10, "R10 ocp_mode");
        wr(4'h7, 8'hC3);
        rd(4'h7, 8'hC3, "R2 readback 7h");
        check({30'h0, csa_gain}, 2'b11, "R10 csa_gain");
        wr(4'h8, 8'hFF);
        rd(4'h8, 8'h3F, "R3 8h upper zero");
        wr(4'hC, 8'hFF);
        rd(4'hC, 8'h1F, "R3 Ch upper zero");
        check({28'h0, dly_target}, 4'hF, "R10 dly_target");

        // R4 unmapped write
        wr(4'h9, 8'hFF);
        wr(4'h0, 8'h06);
        rd(4'h9, 8'h00, "R4 unmapped readback");
        rd(4'h4, 8'hFE, "R4 4h unchanged");
        rd(4'h6, 8'h5A, "R4 6h unchanged");
        check({31'h0, locked}, 0, "R4 no lock from offset 0");

        // R8 clear-fault pulse
        wr(4'h4, 8'h61);
        check({31'h0, clr_fault}, 1, "R8 pulse high");
        @(negedge clk);
        check({31'h0, clr_fault}, 0, "R8 pulse one cycle");
        rd(4'h4, 8'h60, "R8 bit0 self-clear");

        // R5 / R7 / R6 lock behaviour
        wr(4'h3, 8'h06);
        check({31'h0, locked}, 1, "R5 lock set");
        wr(4'h6, 8'h00);
        rd(4'h6, 8'h5A, "R5 6h frozen");
        check({30'h0, ocp_mode}, 2'b10, "R5 ocp_mode frozen");
        wr(4'h4, 8'h01);
        check({31'h0, clr_fault}, 0, "R8 no pulse when locked");
        @(negedge clk);
        check({31'h0, clr_fault}, 0, "R8 no pulse when locked later");
        rd(4'h4, 8'h60, "R5 4h frozen");
        wr(4'h3, 8'h05);
        check({31'h0, locked}, 1, "R6 other code keeps lock");
        rd(4'h3, 8'h05, "R7 lock field writable");
        wr(4'h3, 8'h03);
        check({31'h0, locked}, 0, "R6 unlock");
        wr(4'h6, 8'h33);
        rd(4'h6, 8'h33, "R2 write after unlock");

        // R9 hold and side-effect free reads
        rd(4'h7, 8'hC3, "R9 repeat read 1");
        rd(4'h7, 8'hC3, "R9 repeat read 2");
        repeat (3) @(negedge clk);
        check({24'h0, rdata}, 8'hC3, "R9 rdata holds");

        repeat (3) @(negedge clk);
        check(sb.size(), 0, "R9 scoreboard drained");
        finish_run();
    end

endmodule